// File: doc/BRIEF.md
# Output Pixel Format Packer

This block sits at the output end of a 2D graphics copy engine. Each pixel arrives as four 8-bit components (alpha, red, green, blue). A single register stage turns it into an output word in one of five color formats. Before the word is built, red and blue can be exchanged and alpha can be complemented. Pixels move through a valid/ready stream on both sides.

A small register file holds the packing configuration and a constant fill color, and software writes it over a simple write strobe. A start pulse marks a transfer as running and a done pulse ends it. While a transfer runs, the configuration and the color register ignore writes, so the format cannot change in the middle of an image.

Top module: `pixel_out_packer`

## Requirements
- R1: With mode code 000 (ARGB8888), the output word is alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.
- R2: With mode code 001 (RGB888), the output is red, green and blue as 8-bit fields, right-aligned, with bits 31:24 zero.
- R3: With mode code 010 (RGB565), red[7:3] goes to bits 15:11, green[7:2] to 10:5, blue[7:3] to 4:0, and bits 31:16 are zero.
- R4: With mode code 011 (ARGB1555), bit 15 is the MSB of the alpha after any inversion, bits 14:0 hold the top 5 bits of red, green and blue (red highest), and bits 31:16 are zero.
- R5: With mode code 100 (ARGB4444), bits 15:0 hold the top nibbles of alpha, red, green and blue, alpha highest, and bits 31:16 are zero.
- R6: When the swap bit (bit 21 of the control register) is 1, red and blue exchange places in every format.
- R7: When the invert bit (bit 20 of the control register) is 1, the alpha used in the output is the bitwise complement of the input alpha.
- R8: Mode codes 101, 110 and 111 give an output word of zero, and `out_fmt_err` is 1 for that word. For the defined codes `out_fmt_err` is 0.
- R9: Writes to the control register (address 0) and the color register (address 1) take effect only while `busy` is 0. While `busy` is 1 they are dropped, and the readback shows the old value.
- R10: The control register reads back the mode in bits 2:0, the invert bit in 20 and the swap bit in 21. All other bits read as zero whatever was written.
- R11: `xfer_start` sets `busy` when it is 0, and `xfer_done` clears it. A start while busy leaves it set, and done wins when both pulse together.
- R12: `out_valid` rises in the cycle after a pixel is accepted, and `in_ready` is high exactly when the output stage is empty or `out_ready` is high. A word held under backpressure stays stable.
- R13: After reset, `busy` and `out_valid` are 0 and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 color |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_done | input | 1 | Transfer end pulse |
| busy | output | 1 | Transfer active, configuration locked |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with valid |
| in_pixel | input | 32 | Pixel as {alpha, red, green, blue} |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 32 | Packed output word |
| out_fmt_err | output | 1 | Word was produced under an undefined mode code |

## Verification
The bench builds the block with its default parameters, so both registers reset to zero and the component width is 8 bits. This covers all eight mode codes, each with every combination of swap and invert. Those are pushed through pixels chosen to separate the high bits of each component from the low bits. Random downstream stalls exercise the hold path. Lock tests write while a transfer runs, and the reserved control bits are written as ones.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    localparam int CH_W     = 8;
    localparam int WORD_W   = 4 * CH_W;
    localparam int MODE_W   = 3;
    localparam int SWAP_POS = 21;
    localparam int INV_POS  = 20;

    typedef enum logic [MODE_W-1:0] {
        FMT_ARGB8888 = 3'd0,
        FMT_RGB888   = 3'd1,
        FMT_RGB565   = 3'd2,
        FMT_ARGB1555 = 3'd3,
        FMT_ARGB4444 = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef struct packed {
        logic              swap;
        logic              inv;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] word;
    } packed_t;

    function automatic argb_t adjust_px(argb_t p, logic swap, logic inv);
        argb_t q;
        q   = p;
        q.r = swap ? p.b : p.r;
        q.b = swap ? p.r : p.b;
        q.a = inv ? ~p.a : p.a;
        return q;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_word(cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_W-1:0] = c.mode;
        w[SWAP_POS]   = c.swap;
        w[INV_POS]    = c.inv;
        return w;
    endfunction

endpackage

// File: rtl/pfp_cfg_regs.sv
module pfp_cfg_regs
    import pfp_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_COLOR = '0,
    parameter logic [MODE_W-1:0] RST_MODE  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              start,
    input  logic              done,
    output logic              busy,
    output cfg_t              cfg,
    output logic [WORD_W-1:0] rdata
);

    cfg_t              cfg_q;
    logic [WORD_W-1:0] color_q;
    logic              busy_q;
    logic              wr_ok;

    assign wr_ok = we && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{swap: 1'b0, inv: 1'b0, mode: RST_MODE};
            color_q <= RST_COLOR;
            busy_q  <= 1'b0;
        end else begin
            if (wr_ok && !addr) begin
                cfg_q.mode <= wdata[MODE_W-1:0];
                cfg_q.swap <= wdata[SWAP_POS];
                cfg_q.inv  <= wdata[INV_POS];
            end
            if (wr_ok && addr) begin
                color_q <= wdata;
            end
            if (done) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
            end
        end
    end

    assign busy  = busy_q;
    assign cfg   = cfg_q;
    assign rdata = addr ? color_q : ctrl_word(cfg_q);

    p_lock_r9: assert property (@(posedge clk) disable iff (rst)
        busy_q && we |=> $stable(cfg_q) && $stable(color_q));

    p_start_r11: assert property (@(posedge clk) disable iff (rst)
        start && !done |=> busy_q);

    p_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);

    p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
        !addr |-> (rdata & ~((32'h1 << SWAP_POS) | (32'h1 << INV_POS) | 32'h7)) == '0);

endmodule

// File: rtl/pfp_format.sv
module pfp_format
    import pfp_pkg::*;
(
    input  argb_t   px,
    input  cfg_t    cfg,
    output packed_t res
);

    argb_t q;

    always_comb begin
        q        = adjust_px(px, cfg.swap, cfg.inv);
        res.err  = 1'b0;
        res.word = '0;
        case (cfg.mode)
            FMT_ARGB8888: res.word = {q.a, q.r, q.g, q.b};
            FMT_RGB888:   res.word = {{CH_W{1'b0}}, q.r, q.g, q.b};
            FMT_RGB565:   res.word = {16'h0, q.r[CH_W-1 -: 5], q.g[CH_W-1 -: 6],
                                      q.b[CH_W-1 -: 5]};
            FMT_ARGB1555: res.word = {16'h0, q.a[CH_W-1], q.r[CH_W-1 -: 5],
                                      q.g[CH_W-1 -: 5], q.b[CH_W-1 -: 5]};
            FMT_ARGB4444: res.word = {16'h0, q.a[CH_W-1 -: 4], q.r[CH_W-1 -: 4],
                                      q.g[CH_W-1 -: 4], q.b[CH_W-1 -: 4]};
            default:      res.err  = 1'b1;
        endcase
    end

endmodule

// File: rtl/pfp_stage.sv
module pfp_stage #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (in_valid && in_ready) begin
            vld_q <= 1'b1;
            dat_q <= in_data;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        vld_q && !out_ready |=> vld_q && $stable(dat_q));

    p_fill_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> vld_q);

    p_drain_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid && out_ready |=> !vld_q);

endmodule

// File: rtl/pixel_out_packer.sv
module pixel_out_packer
    import pfp_pkg::*;
#(
    parameter logic [31:0] RST_COLOR = '0,
    parameter logic [2:0]  RST_MODE  = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xfer_start,
    input  logic        xfer_done,
    output logic        busy,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_pixel,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic        out_fmt_err
);

    localparam int STG_W = $bits(packed_t);

    cfg_t    cfg;
    packed_t fmt_res;
    packed_t stg_out;

    pfp_cfg_regs #(
        .RST_COLOR(RST_COLOR),
        .RST_MODE (RST_MODE)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .start(xfer_start),
        .done (xfer_done),
        .busy (busy),
        .cfg  (cfg),
        .rdata(reg_rdata)
    );

    pfp_format u_fmt (
        .px (argb_t'(in_pixel)),
        .cfg(cfg),
        .res(fmt_res)
    );

    pfp_stage #(.W(STG_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (fmt_res),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (stg_out)
    );

    assign out_word    = stg_out.word;
    assign out_fmt_err = stg_out.err;

    p_undef_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (cfg.mode > 3'd4) |=> out_fmt_err && (out_word == '0));

    p_plain_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && cfg == '0 |=> out_word == $past(in_pixel) && !out_fmt_err);

    p_narrow_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (cfg.mode >= 3'd2) |=> out_word[31:16] == '0);

endmodule

// File: tb/test_pixel_out_packer.sv
module test_pixel_out_packer;

    typedef struct {
        logic [31:0] word;
        logic        err;
        int          mode;
        logic        swap;
        logic        inv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        busy;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_fmt_err;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];
    int   rdy_mode = 1;          // 0 random, 1 always high, 2 always low
    logic [15:0] lfsr = 16'hACE1;
    int   t_mode = 0;
    logic t_swap = 1'b0;
    logic t_inv = 1'b0;

    always #5 clk = ~clk;

    pixel_out_packer i_pixel_out_packer (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .busy(busy),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_fmt_err(out_fmt_err)
    );

    task automatic chk(input logic ok, input string tag, input logic [32:0] act,
                       input logic [32:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] px, input int mode,
                                   input logic swap, input logic inv);
        exp_t e;
        logic [7:0] a, r, g, b;
        a = inv ? ~px[31:24] : px[31:24];
        r = swap ? px[7:0] : px[23:16];
        g = px[15:8];
        b = swap ? px[23:16] : px[7:0];
        e.err = 1'b0; e.mode = mode; e.swap = swap; e.inv = inv;
        case (mode)
            0: e.word = {a, r, g, b};
            1: e.word = {8'h00, r, g, b};
            2: e.word = {16'h0, r[7:3], g[7:2], b[7:3]};
            3: e.word = {16'h0, a[7], r[7:3], g[7:3], b[7:3]};
            4: e.word = {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]};
            default: begin e.word = '0; e.err = 1'b1; end
        endcase
        return e;
    endfunction

    function automatic string mode_tag(input int mode);
        case (mode)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R8";
        endcase
    endfunction

    // downstream ready driver
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready <= lfsr[0] | lfsr[3];
            1: out_ready <= 1'b1;
            default: out_ready <= 1'b0;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R12 unexpected output", {out_fmt_err, out_word}, 33'h0);
            end else begin
                exp_t e;
                string tg;
                e = sb.pop_front();
                tg = $sformatf("%s word mode=%0d (R6 swap=%0d, R7 inv=%0d)",
                               mode_tag(e.mode), e.mode, e.swap, e.inv);
                chk({out_fmt_err, out_word} == {e.err, e.word}, tg,
                    {out_fmt_err, out_word}, {e.err, e.word});
            end
        end
    end

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic s, input logic dn);
        @(posedge clk); #1;
        xfer_start = s; xfer_done = dn;
        @(posedge clk); #1;
        xfer_start = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic send(input logic [31:0] px);
        bit taken;
        taken = 0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_pixel = px;
        while (!taken) begin
            @(negedge clk);
            if (in_ready) begin
                sb.push_back(model(px, t_mode, t_swap, t_inv));
                taken = 1;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] pix [5];
        pix[0] = 32'h80FF4001; pix[1] = 32'h7F123456; pix[2] = 32'hFFFFFFFF;
        pix[3] = 32'h00000000; pix[4] = 32'hC3A55A3C;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R13 reset state
        @(negedge clk);
        chk(busy == 1'b0, "R13 busy after reset", {32'h0, busy}, 33'h0);
        chk(out_valid == 1'b0, "R13 out_valid after reset", {32'h0, out_valid}, 33'h0);
        reg_read(1'b0, rd);
        chk(rd == 32'h0, "R13 control reset", {1'b0, rd}, 33'h0);
        reg_read(1'b1, rd);
        chk(rd == 32'h0, "R13 color reset", {1'b0, rd}, 33'h0);

        // R10 reserved bits
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, rd);
        chk(rd == 32'h0030_0007, "R10 control readback", {1'b0, rd}, {1'b0, 32'h0030_0007});
        reg_write(1'b0, 32'h0000_0000);

        // R11 start/done
        pulse(1'b1, 1'b0);
        @(negedge clk);
        chk(busy == 1'b1, "R11 start sets busy", {32'h0, busy}, 33'h1);
        pulse(1'b1, 1'b0);
        @(negedge clk);
        chk(busy == 1'b1, "R11 start while busy", {32'h0, busy}, 33'h1);
        pulse(1'b1, 1'b1);
        @(negedge clk);
        chk(busy == 1'b0, "R11 done wins over start", {32'h0, busy}, 33'h0);

        // R12 latency, ready, hold
        rdy_mode = 2;
        repeat (2) @(posedge clk);
        t_mode = 0; t_swap = 1'b0; t_inv = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_pixel = 32'h11223344;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12 ready when empty", {32'h0, in_ready}, 33'h1);
        sb.push_back(model(32'h11223344, 0, 1'b0, 1'b0));
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R12 valid one cycle later", {32'h0, out_valid}, 33'h1);
        repeat (3) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R12 not ready when full and stalled", {32'h0, in_ready}, 33'h0);
            chk(out_word == 32'h11223344, "R12 held word stable", {1'b0, out_word},
                {1'b0, 32'h11223344});
        end
        rdy_mode = 1;
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R12 ready when consumed", {32'h0, in_ready}, 33'h1);
        drain();

        // all modes with swap/invert, random backpressure, lock checks
        rdy_mode = 0;
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] cw;
                t_mode = m; t_swap = k[1]; t_inv = k[0];
                cw = {10'h0, t_swap, t_inv, 17'h0, 3'(m)};
                reg_write(1'b0, cw);
                reg_write(1'b1, {8'(m), 8'(k), 16'h5AA5});
                pulse(1'b1, 1'b0);
                // R9 writes during busy are dropped
                reg_write(1'b0, ~cw);
                reg_write(1'b1, 32'hDEAD_BEEF);
                reg_read(1'b0, rd);
                chk(rd == cw, "R9 control locked while busy", {1'b0, rd}, {1'b0, cw});
                reg_read(1'b1, rd);
                chk(rd == {8'(m), 8'(k), 16'h5AA5}, "R9 color locked while busy",
                    {1'b0, rd}, {1'b0, 8'(m), 8'(k), 16'h5AA5});
                for (int p = 0; p < 5; p++) send(pix[p]);
                drain();
                pulse(1'b0, 1'b1);
            end
        end

        // R9 writes accepted when idle
        reg_write(1'b1, 32'h1234_5678);
        reg_read(1'b1, rd);
        chk(rd == 32'h1234_5678, "R9 color write when idle", {1'b0, rd}, {1'b0, 32'h1234_5678});

        rdy_mode = 1;
        repeat (4) @(posedge clk);
        chk(sb.size() == 0, "R12 scoreboard empty at end", 33'(sb.size()), 33'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule